// File: doc/BRIEF.md
# Partitionable Multi-Stage Trigger Sequencer

This block turns a vector of eight already-qualified match signals into trigger events for a capture engine. A shared pool of sixteen trigger stages is split, by a partition code chosen at arm time, into one to four independent sequencers. Each sequencer walks its own stages in order. A stage waits until its condition has been seen on a programmed number of valid samples, then hands over to the next stage. When the last stage of a sequencer completes, that sequencer raises a sticky done flag.

A single trigger output is derived either from the done flag of one chosen sequencer or from a sum-of-products over the match inputs. The sum-of-products has eight product terms, each an AND of a chosen subset of the match inputs. A one-cycle trigger pulse is given the first time the chosen source becomes true after arming. All configuration is captured when `arm_i` is pulsed, so software may rewrite the configuration inputs while a run is in progress without disturbing it.

Top module: `trig_sequencer`

## Requirements
- R1: The partition code `cfg_part_i` selects the split of stages 0..15 into sequencers. Code 1 gives seq0 = stages 0-7 and seq1 = 8-15. Code 2 gives seq k = stages 4k..4k+3. Code 3 gives seq0 = 0-7, seq1 = 8-11 and seq2 = 12-15. Code 4 gives seq0 = 0-11 and seq1 = 12-15. Code 0 and codes 5-7 give a single seq0 over stages 0-15. A sequencer that a code leaves unused never sets its done flag.
- R2: Stage s holds a mask in `cfg_stage_mask_i[s*8 +: 8]`. The stage's condition is true on a cycle with `valid_i` = 1 when every masked bit of `match_i` is 1. An all-zero mask never matches, and cycles with `valid_i` = 0 are never counted.
- R3: Stage s holds a pass count in `cfg_stage_count_i[s*20 +: 20]` (20 bits). The stage advances once its condition has been counted that many times; the counted cycles need not be consecutive. A count of 0 behaves like 1.
- R4: Completing the last stage of sequencer k sets `seq_done_o[k]` on the next clock edge. Once set, the flag stays set and that sequencer ignores further input until the next arm.
- R5: Sequencers in one partition advance independently. A hit in one sequencer neither advances nor blocks another.
- R6: All configuration inputs are sampled only in the cycle where `arm_i` = 1. Later changes to them have no effect until the next arm.
- R7: Source code `cfg_src_i` 0-3 selects the done flag of sequencer 0-3, and codes 4-7 select the sum-of-products. `trig_o` is a single-cycle pulse. It is given on the first occasion after arming that the selected source becomes true, and not again until the next arm. For a sequencer source, the pulse appears in the same cycle that the done flag first reads 1.
- R8: Product term t uses `cfg_sop_mask_i[t*8 +: 8]`. A term is true when its mask is non-zero and every masked match bit is 1. The sum-of-products is the OR of the eight terms, qualified by `valid_i`, and a true result gives the trigger pulse in the next cycle.
- R9: After reset, `seq_done_o` = 0, `trig_o` = 0 and the block is disarmed. Until the first arm, no input changes any output.
- R10: An arm cycle clears every sequencer to its first stage with a zero count and clears all done flags and the trigger history. Match data presented in the arm cycle itself is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_i | input | 1 | Arm pulse: captures configuration and restarts all sequencers |
| valid_i | input | 1 | Sample-valid strobe qualifying match_i |
| match_i | input | 8 | Qualified match-circuit outputs |
| cfg_part_i | input | 3 | Partition code |
| cfg_src_i | input | 3 | Trigger source code |
| cfg_stage_mask_i | input | 128 | Per-stage match masks, 8 bits per stage |
| cfg_stage_count_i | input | 320 | Per-stage pass counts, 20 bits per stage |
| cfg_sop_mask_i | input | 64 | Product-term masks, 8 bits per term |
| seq_done_o | output | 4 | Sticky done flag per sequencer |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The hardest situation to reach from the ports is a pass count near its limit in a stage that is not the first, interleaved with hits to other partitions on the same samples. The stimulus table gets there by giving a middle stage a count of three and feeding match words that hit several sequencers at once, with invalid samples between them. Directed runs then step through every partition code with uniform masks, so that the pattern of done flags shows where each boundary lies. Further directed runs apply a count of one thousand and rewrite the configuration after arming. A final run presents hits in the arm cycle itself.

// File: rtl/trig_seq_pkg.sv
// Package: shared constants, partition codes and the partition map function
// for the trigger sequencer. Assumes a fixed pool of sixteen stages split
// into at most four sequencers.
package trig_seq_pkg;

    localparam int STAGES = 16;
    localparam int SEQS   = 4;
    localparam int SIDX_W = $clog2(STAGES);
    localparam int SEQ_W  = $clog2(SEQS);

    typedef enum logic [2:0] {
        PART_ONE16   = 3'd0,
        PART_TWO8    = 3'd1,
        PART_FOUR4   = 3'd2,
        PART_EIGHT44 = 3'd3,
        PART_TWELVE4 = 3'd4
    } part_code_e;

    typedef struct packed {
        logic              en;
        logic [SIDX_W-1:0] first;
        logic [SIDX_W-1:0] last;
    } seq_span_t;

    // Returns the stage window owned by sequencer k under partition code pc.
    function automatic seq_span_t span_of(input logic [2:0] pc, input int k);
        seq_span_t s;
        s = '{en: 1'b0, first: '0, last: '0};
        case (pc)
            PART_TWO8: begin
                if (k < 2) begin
                    s.en    = 1'b1;
                    s.first = SIDX_W'(k * 8);
                    s.last  = SIDX_W'(k * 8 + 7);
                end
            end
            PART_FOUR4: begin
                s.en    = 1'b1;
                s.first = SIDX_W'(k * 4);
                s.last  = SIDX_W'(k * 4 + 3);
            end
            PART_EIGHT44: begin
                if (k == 0) begin
                    s = '{en: 1'b1, first: SIDX_W'(0), last: SIDX_W'(7)};
                end else if (k < 3) begin
                    s.en    = 1'b1;
                    s.first = SIDX_W'(4 + k * 4);
                    s.last  = SIDX_W'(7 + k * 4);
                end
            end
            PART_TWELVE4: begin
                if (k == 0) begin
                    s = '{en: 1'b1, first: SIDX_W'(0), last: SIDX_W'(11)};
                end else if (k == 1) begin
                    s = '{en: 1'b1, first: SIDX_W'(12), last: SIDX_W'(15)};
                end
            end
            default: begin
                if (k == 0) begin
                    s = '{en: 1'b1, first: SIDX_W'(0), last: SIDX_W'(STAGES - 1)};
                end
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/trig_seq_partition.sv
// Partition decoder: expands a partition code into a per-sequencer enable
// and stage window. Purely combinational; assumes the code is stable while
// armed (the top feeds it the latched code except in the arm cycle).
module trig_seq_partition
    import trig_seq_pkg::*;
(
    input  logic [2:0]                   part_i,
    output logic [SEQS-1:0]              en_o,
    output logic [SEQS-1:0][SIDX_W-1:0]  first_o,
    output logic [SEQS-1:0][SIDX_W-1:0]  last_o
);

    for (genvar k = 0; k < SEQS; k++) begin : g_span
        seq_span_t sp;
        // Decode the window of sequencer k.
        always_comb begin
            sp         = span_of(part_i, k);
            en_o[k]    = sp.en;
            first_o[k] = sp.first;
            last_o[k]  = sp.last;
        end
    end

endmodule

// File: rtl/trig_seq_engine.sv
// Sequencer engine: walks the stages first_i..last_i of the shared pool,
// counting valid samples that satisfy the current stage mask, and sets a
// sticky done flag after the last stage. Assumes configuration is stable
// between arm pulses and that first_i <= last_i.
module trig_seq_engine
    import trig_seq_pkg::*;
#(
    parameter int N_MATCH = 8,
    parameter int CNT_W   = 20
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               arm_i,
    input  logic                               en_i,
    input  logic [SIDX_W-1:0]                  first_i,
    input  logic [SIDX_W-1:0]                  last_i,
    input  logic [STAGES-1:0][N_MATCH-1:0]     mask_i,
    input  logic [STAGES-1:0][CNT_W-1:0]       count_i,
    input  logic                               valid_i,
    input  logic [N_MATCH-1:0]                 match_i,
    output logic                               done_o,
    output logic                               done_nx_o
);

    logic [SIDX_W-1:0] stg_q, stg_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              done_q, done_d;
    logic [N_MATCH-1:0] cur_mask;
    logic [CNT_W-1:0]   cur_need;
    logic               hit;
    logic               reached;

    // Current stage condition and effective pass count (0 acts as 1).
    always_comb begin
        cur_mask = mask_i[stg_q];
        cur_need = (count_i[stg_q] == '0) ? CNT_W'(1) : count_i[stg_q];
        hit      = en_i && !done_q && valid_i && (|cur_mask)
                   && ((match_i & cur_mask) == cur_mask);
        reached  = ({1'b0, cnt_q} + 1'b1) >= {1'b0, cur_need};
    end

    // Next-state: arm restarts, a hit counts or advances, last stage finishes.
    always_comb begin
        stg_d  = stg_q;
        cnt_d  = cnt_q;
        done_d = done_q;
        if (arm_i) begin
            stg_d  = first_i;
            cnt_d  = '0;
            done_d = 1'b0;
        end else if (hit) begin
            if (reached) begin
                cnt_d = '0;
                if (stg_q == last_i) begin
                    done_d = 1'b1;
                end else begin
                    stg_d = stg_q + 1'b1;
                end
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            stg_q  <= stg_d;
            cnt_q  <= cnt_d;
            done_q <= done_d;
        end
    end

    assign done_o    = done_q;
    assign done_nx_o = done_d;

    // R1: an active engine never leaves its own stage window.
    p_stage_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !arm_i) |-> (stg_q >= first_i && stg_q <= last_i));

    // R3: the pass counter stays below the effective count of its stage.
    p_count_below_need_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !arm_i && !done_q) |-> (cnt_q < cur_need));

    // R4: done stays set until the next arm.
    p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !arm_i) |=> done_q);

    // R10: an arm cycle leaves the engine at its first stage, cleared.
    p_arm_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (!done_q && cnt_q == '0));

endmodule

// File: rtl/trig_seq_sop.sv
// Sum-of-products trigger term: N_TERM product terms, each an AND over a
// masked subset of the match inputs; the result is their OR, qualified by
// the sample strobe and the armed state. An all-zero term mask is false.
module trig_seq_sop #(
    parameter int N_MATCH = 8,
    parameter int N_TERM  = 8
) (
    input  logic [N_TERM-1:0][N_MATCH-1:0] term_mask_i,
    input  logic [N_MATCH-1:0]             match_i,
    input  logic                           valid_i,
    input  logic                           armed_i,
    output logic                           hit_o
);

    logic [N_TERM-1:0] term_true;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        // Evaluate product term t.
        assign term_true[t] = (|term_mask_i[t])
                              && ((match_i & term_mask_i[t]) == term_mask_i[t]);
    end

    // OR of all terms on a valid sample while armed.
    assign hit_o = armed_i && valid_i && (|term_true);

endmodule

// File: rtl/trig_seq_out.sv
// Trigger output stage: selects a source (one sequencer's next done value
// or the sum-of-products hit) and emits a single registered pulse on the
// first occasion it is true after arming. Assumes src is stable while armed.
module trig_seq_out
    import trig_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm_i,
    input  logic            armed_i,
    input  logic [2:0]      src_i,
    input  logic [SEQS-1:0] done_nx_i,
    input  logic            sop_hit_i,
    output logic            trig_o
);

    logic src_true;
    logic fired_q;
    logic fire;

    // Source selection: codes below SEQS pick a sequencer, the rest the SOP.
    always_comb begin
        if (src_i < 3'(SEQS)) begin
            src_true = done_nx_i[src_i[SEQ_W-1:0]];
        end else begin
            src_true = sop_hit_i;
        end
        fire = armed_i && !arm_i && !fired_q && src_true;
    end

    // Pulse register and one-shot history, cleared by arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_o  <= 1'b0;
            fired_q <= 1'b0;
        end else if (arm_i) begin
            trig_o  <= 1'b0;
            fired_q <= 1'b0;
        end else begin
            trig_o  <= fire;
            fired_q <= fired_q || fire;
        end
    end

    // R7: the trigger is never high on two consecutive cycles.
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R7: no second pulse before a new arm.
    p_no_refire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fired_q && !arm_i) |=> !trig_o);

endmodule

// File: rtl/trig_sequencer.sv
// Top of the partitionable trigger sequencer. Captures all configuration on
// the arm pulse, decodes the partition, runs one engine per possible
// sequencer over the shared stage pool, and drives the trigger output.
// Assumes match_i is already qualified and synchronous to clk.
module trig_sequencer
    import trig_seq_pkg::*;
#(
    parameter int N_MATCH = 8,
    parameter int CNT_W   = 20,
    parameter int N_TERM  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          arm_i,
    input  logic                          valid_i,
    input  logic [N_MATCH-1:0]            match_i,
    input  logic [2:0]                    cfg_part_i,
    input  logic [2:0]                    cfg_src_i,
    input  logic [STAGES*N_MATCH-1:0]     cfg_stage_mask_i,
    input  logic [STAGES*CNT_W-1:0]       cfg_stage_count_i,
    input  logic [N_TERM*N_MATCH-1:0]     cfg_sop_mask_i,
    output logic [SEQS-1:0]               seq_done_o,
    output logic                          trig_o
);

    logic                               armed_q;
    logic [2:0]                         part_q;
    logic [2:0]                         src_q;
    logic [STAGES-1:0][N_MATCH-1:0]     smask_q;
    logic [STAGES-1:0][CNT_W-1:0]       scount_q;
    logic [N_TERM-1:0][N_MATCH-1:0]     sop_q;

    logic [2:0]                         part_sel;
    logic [SEQS-1:0]                    part_en;
    logic [SEQS-1:0][SIDX_W-1:0]        part_first;
    logic [SEQS-1:0][SIDX_W-1:0]        part_last;
    logic [SEQS-1:0]                    done_nx;
    logic                               sop_hit;

    // Configuration shadow and armed flag, loaded only by the arm pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            part_q   <= '0;
            src_q    <= '0;
            smask_q  <= '0;
            scount_q <= '0;
            sop_q    <= '0;
        end else if (arm_i) begin
            armed_q  <= 1'b1;
            part_q   <= cfg_part_i;
            src_q    <= cfg_src_i;
            smask_q  <= cfg_stage_mask_i;
            scount_q <= cfg_stage_count_i;
            sop_q    <= cfg_sop_mask_i;
        end
    end

    // Engines restart against the incoming code in the arm cycle.
    assign part_sel = arm_i ? cfg_part_i : part_q;

    trig_seq_partition i_part (
        .part_i  (part_sel),
        .en_o    (part_en),
        .first_o (part_first),
        .last_o  (part_last)
    );

    for (genvar k = 0; k < SEQS; k++) begin : g_seq
        trig_seq_engine #(
            .N_MATCH (N_MATCH),
            .CNT_W   (CNT_W)
        ) i_eng (
            .clk       (clk),
            .rst_n     (rst_n),
            .arm_i     (arm_i),
            .en_i      (armed_q && part_en[k]),
            .first_i   (part_first[k]),
            .last_i    (part_last[k]),
            .mask_i    (smask_q),
            .count_i   (scount_q),
            .valid_i   (valid_i),
            .match_i   (match_i),
            .done_o    (seq_done_o[k]),
            .done_nx_o (done_nx[k])
        );

        // R1: a sequencer the partition leaves unused stays idle.
        p_unused_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!arm_i && !part_en[k]) |-> !seq_done_o[k]);
    end

    trig_seq_sop #(
        .N_MATCH (N_MATCH),
        .N_TERM  (N_TERM)
    ) i_sop (
        .term_mask_i (sop_q),
        .match_i     (match_i),
        .valid_i     (valid_i),
        .armed_i     (armed_q && !arm_i),
        .hit_o       (sop_hit)
    );

    trig_seq_out i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_i     (arm_i),
        .armed_i   (armed_q),
        .src_i     (src_q),
        .done_nx_i (done_nx),
        .sop_hit_i (sop_hit),
        .trig_o    (trig_o)
    );

    // R9: nothing is reported before the first arm.
    p_idle_before_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (seq_done_o == '0 && !trig_o));

    // R7: a sequencer-sourced pulse coincides with that sequencer being done.
    p_trig_follows_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && src_q < 3'(SEQS)) |-> seq_done_o[src_q[SEQ_W-1:0]]);

endmodule

// File: tb/test_trig_sequencer.sv
// Bench for trig_sequencer: a vector table walked by one loop, then
// directed runs for reset, partitions, counts, arming and the SOP source.
module test_trig_sequencer;

    localparam int NM = 8;
    localparam int CW = 20;
    localparam int NS = 16;
    localparam int NT = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arm_i = 1'b0;
    logic              valid_i = 1'b0;
    logic [NM-1:0]     match_i = '0;
    logic [2:0]        cfg_part_i = '0;
    logic [2:0]        cfg_src_i = '0;
    logic [NS*NM-1:0]  cfg_stage_mask_i = '0;
    logic [NS*CW-1:0]  cfg_stage_count_i = '0;
    logic [NT*NM-1:0]  cfg_sop_mask_i = '0;
    logic [3:0]        seq_done_o;
    logic              trig_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    trig_sequencer i_trig_sequencer (
        .clk               (clk),
        .rst_n             (rst_n),
        .arm_i             (arm_i),
        .valid_i           (valid_i),
        .match_i           (match_i),
        .cfg_part_i        (cfg_part_i),
        .cfg_src_i         (cfg_src_i),
        .cfg_stage_mask_i  (cfg_stage_mask_i),
        .cfg_stage_count_i (cfg_stage_count_i),
        .cfg_sop_mask_i    (cfg_sop_mask_i),
        .seq_done_o        (seq_done_o),
        .trig_o            (trig_o)
    );

    // Vector: {match[13:6], valid[5], exp_done[4:1], exp_trig[0]}, for
    // partition code 2, source seq1 (see table setup below).
    localparam logic [13:0] VEC [15] = '{
        {8'h01, 1'b1, 4'b0000, 1'b0},
        {8'h01, 1'b0, 4'b0000, 1'b0},
        {8'h03, 1'b1, 4'b0000, 1'b0},
        {8'h04, 1'b1, 4'b0000, 1'b0},
        {8'h0C, 1'b1, 4'b0000, 1'b0},
        {8'h03, 1'b1, 4'b0000, 1'b0},
        {8'h03, 1'b1, 4'b0001, 1'b0},
        {8'h02, 1'b1, 4'b0001, 1'b0},
        {8'h0C, 1'b1, 4'b0001, 1'b0},
        {8'h02, 1'b0, 4'b0001, 1'b0},
        {8'h02, 1'b1, 4'b0001, 1'b0},
        {8'h0C, 1'b1, 4'b0001, 1'b0},
        {8'h0E, 1'b1, 4'b0111, 1'b1},
        {8'h0E, 1'b1, 4'b0111, 1'b0},
        {8'hFF, 1'b1, 4'b0111, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: inputs applied after a falling edge, outputs read at the next.
    task automatic step(input logic [NM-1:0] m, input logic v);
        match_i = m;
        valid_i = v;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic hits(input int n, input logic [NM-1:0] m);
        for (int i = 0; i < n; i++) step(m, 1'b1);
    endtask

    task automatic arm();
        arm_i = 1'b1;
        step('0, 1'b0);
        arm_i = 1'b0;
    endtask

    task automatic set_uniform(input logic [NM-1:0] m, input logic [CW-1:0] c);
        for (int s = 0; s < NS; s++) begin
            cfg_stage_mask_i[s*NM +: NM]  = m;
            cfg_stage_count_i[s*CW +: CW] = c;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        @(negedge clk);
        chk("R9 reset done", 32'(seq_done_o), 32'h0);
        chk("R9 reset trig", 32'(trig_o), 32'h0);
        rst_n = 1'b1;
        set_uniform(8'h01, 20'd1);
        hits(20, 8'hFF);
        chk("R9 no progress before arm", 32'(seq_done_o), 32'h0);
        chk("R9 no trig before arm", 32'(trig_o), 32'h0);

        // Table run: partition code 2, source seq1.
        cfg_part_i = 3'd2;
        cfg_src_i  = 3'd1;
        for (int s = 0; s < 4; s++) begin
            cfg_stage_mask_i[s*NM +: NM]      = 8'h01;
            cfg_stage_count_i[s*CW +: CW]     = 20'd1;
            cfg_stage_mask_i[(4+s)*NM +: NM]  = 8'h02;
            cfg_stage_count_i[(4+s)*CW +: CW] = 20'd0;
            cfg_stage_mask_i[(8+s)*NM +: NM]  = 8'h0C;
            cfg_stage_count_i[(8+s)*CW +: CW] = 20'd1;
            cfg_stage_mask_i[(12+s)*NM +: NM] = 8'h10;
        end
        cfg_stage_count_i[4*CW +: CW] = 20'd3;
        cfg_stage_mask_i[12*NM +: NM] = 8'h00;
        arm();
        foreach (VEC[i]) begin
            step(VEC[i][13:6], VEC[i][5]);
            chk($sformatf("R2 R3 R4 R5 R7 vec%0d done", i), 32'(seq_done_o), 32'(VEC[i][4:1]));
            chk($sformatf("R7 vec%0d trig", i), 32'(trig_o), 32'(VEC[i][0]));
        end

        // R10: re-arm clears done flags.
        arm();
        chk("R10 rearm clears done", 32'(seq_done_o), 32'h0);

        // R1 code 0: one sequencer of sixteen stages.
        set_uniform(8'h01, 20'd1);
        cfg_part_i = 3'd0;
        cfg_src_i  = 3'd0;
        arm();
        hits(15, 8'h01);
        chk("R1 code0 after 15", 32'(seq_done_o), 32'h0);
        step(8'h01, 1'b1);
        chk("R1 code0 after 16", 32'(seq_done_o), 32'h1);
        chk("R7 seq0 trig", 32'(trig_o), 32'h1);
        step(8'h01, 1'b1);
        chk("R7 pulse one cycle", 32'(trig_o), 32'h0);

        // R1 code 1: two of eight.
        cfg_part_i = 3'd1;
        arm();
        hits(7, 8'h01);
        chk("R1 code1 after 7", 32'(seq_done_o), 32'h0);
        step(8'h01, 1'b1);
        chk("R1 code1 after 8", 32'(seq_done_o), 32'h3);

        // R1 R5 code 3: eight + four + four.
        cfg_part_i = 3'd3;
        arm();
        hits(4, 8'h01);
        chk("R1 R5 code3 after 4", 32'(seq_done_o), 32'h6);
        hits(4, 8'h01);
        chk("R1 code3 after 8", 32'(seq_done_o), 32'h7);

        // R1 code 4: twelve + four.
        cfg_part_i = 3'd4;
        arm();
        hits(4, 8'h01);
        chk("R1 code4 after 4", 32'(seq_done_o), 32'h2);
        hits(8, 8'h01);
        chk("R1 code4 after 12", 32'(seq_done_o), 32'h3);

        // R6: configuration changes after arm are ignored.
        cfg_part_i = 3'd0;
        arm();
        cfg_part_i = 3'd2;
        set_uniform(8'h02, 20'd1);
        hits(4, 8'h01);
        chk("R6 latched partition", 32'(seq_done_o), 32'h0);
        hits(12, 8'h01);
        chk("R6 latched masks", 32'(seq_done_o), 32'h1);

        // R10: match in the arm cycle is not counted.
        set_uniform(8'h01, 20'd1);
        cfg_part_i = 3'd2;
        cfg_src_i  = 3'd3;
        arm_i = 1'b1;
        step(8'h01, 1'b1);
        arm_i = 1'b0;
        hits(3, 8'h01);
        chk("R10 arm cycle ignored", 32'(seq_done_o), 32'h0);
        step(8'h01, 1'b1);
        chk("R10 fourth hit done", 32'(seq_done_o), 32'hF);
        chk("R7 seq3 source", 32'(trig_o), 32'h1);

        // R3: large pass count in first stage.
        cfg_stage_count_i[0*CW +: CW] = 20'd1000;
        arm();
        hits(1002, 8'h01);
        chk("R3 count 1000 not yet", 32'(seq_done_o[0]), 32'h0);
        step(8'h01, 1'b1);
        chk("R3 count 1000 done", 32'(seq_done_o[0]), 32'h1);

        // R8: sum-of-products source.
        cfg_src_i = 3'd4;
        cfg_sop_mask_i = '0;
        cfg_sop_mask_i[0*NM +: NM] = 8'h03;
        cfg_sop_mask_i[1*NM +: NM] = 8'h30;
        set_uniform(8'h00, 20'd1);
        arm();
        step(8'h01, 1'b1);
        chk("R8 partial term", 32'(trig_o), 32'h0);
        step(8'h30, 1'b0);
        chk("R8 invalid sample", 32'(trig_o), 32'h0);
        step(8'h30, 1'b1);
        chk("R8 term1 fires", 32'(trig_o), 32'h1);
        step(8'h30, 1'b1);
        chk("R7 R8 no refire", 32'(trig_o), 32'h0);
        chk("R2 empty masks never done", 32'(seq_done_o), 32'h0);
        cfg_sop_mask_i = '0;
        arm();
        step(8'hFF, 1'b1);
        chk("R8 empty terms false", 32'(trig_o), 32'h0);
        cfg_sop_mask_i[7*NM +: NM] = 8'h80;
        arm();
        step(8'h80, 1'b1);
        chk("R8 term7 fires", 32'(trig_o), 32'h1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule